// File: doc/BRIEF.md
# Divided countdown timer

This block is a local countdown timer for an interrupt controller. Software loads a 32-bit starting value. The block then counts it down at the core clock divided by a selectable power of two, and the present value can be read at any time. Each time the count runs out, the block records one expiry. A one-shot run stops at zero. A periodic run reloads the starting value and keeps going.

Expiries are not kept in a single flag. They go into a small saturating counter. A downstream consumer takes one event off that counter each time it delivers the interrupt. A timer entry register holds the vector, a mask bit, a send-pending bit and the periodic selection. Pending events are offered to the consumer only while software enable is high and the entry is unmasked. Routing the interrupt any further is the consumer's job.

Top module: `divtimer`

## Requirements
- R1: The divider config uses bits [3], [1] and [0] only; exponent = ({cfg[3],cfg[1:0]} + 1) mod 8 and the count steps once every 2^exponent clocks. So 4'hB gives 1, 4'h0 and 4'h4 give 2, and 4'h8 gives 32.
- R2: A starting value of zero leaves the current count at zero, and no expiry is ever recorded.
- R3: A start write loads the current count with the written value on the next clock, restarts the divider phase and clears the pending counter.
- R4: With entry bit 17 (periodic) clear, the count reaches zero after N steps, records one expiry and then holds at zero until the next start write.
- R5: With entry bit 17 set, the step that would reach zero records an expiry and reloads the starting value, and counting continues.
- R6: Each expiry adds one to the pending counter. A delivery accepted while events are offered removes one.
- R7: Events are offered (pend_valid) only while sw_enable is high, entry bit 16 (mask) is clear and the pending count is nonzero. A delivery while nothing is offered changes nothing.
- R8: While sw_enable is low, entry bit 16 is forced to one and the pending counter is held at zero. An entry write during that time stores the mask bit as one.
- R9: The entry keeps only bits [7:0] (vector), 12 (send pending), 16 (mask) and 17 (periodic). Every other bit reads as zero.
- R10: A divider write changes the step rate from the next step onward. It does not reload or restart the count.
- R11: The pending counter stops at its all-ones maximum and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_enable | input | 1 | Software enable for the timer's event reporting |
| init_wr | input | 1 | Strobe: load a new starting value |
| init_data | input | CNT_W | Starting value |
| div_wr | input | 1 | Strobe: write divider config |
| div_data | input | 4 | Divider config |
| entry_wr | input | 1 | Strobe: write timer entry |
| entry_data | input | 32 | Timer entry write word |
| entry_rd | output | 32 | Timer entry read word |
| cur_count | output | CNT_W | Current count |
| pend_count | output | PEND_W | Pending expiry events |
| pend_valid | output | 1 | An event is offered to the consumer |
| deliver | input | 1 | Consumer takes one offered event |

## Verification
The countdown is run at four divider codes. Divide-by-1, divide-by-2 with and without the ignored bit 2, and divide-by-32 are each sampled one step before and one step after an edge. This shows the exponent decode apart from an off-by-one in the divider phase. One-shot and periodic runs are sampled at the step just before expiry, at expiry, and well after it, so a missing reload shows up apart from a missing stop. A periodic run of length one drives expiries on every clock to show saturation. A divider change in the middle of a run shows whether the count is kept or reloaded. Deliveries are made both while events are offered and while the entry is masked, so accepted deliveries can be told from ignored ones.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

    localparam int ENTRY_W   = 32;
    localparam int VEC_W     = 8;
    localparam int SENDP_BIT = 12;
    localparam int MASK_BIT  = 16;
    localparam int PER_BIT   = 17;
    localparam int DIVCFG_W  = 4;
    localparam int EXP_W     = 3;
    localparam int MAX_EXP   = (1 << EXP_W) - 1;

    typedef logic [EXP_W-1:0] div_exp_t;

    typedef struct packed {
        logic             periodic;
        logic             masked;
        logic             send_pend;
        logic [VEC_W-1:0] vector;
    } entry_t;

    localparam entry_t ENTRY_RESET = '{periodic: 1'b0, masked: 1'b1,
                                       send_pend: 1'b0, vector: '0};

    function automatic div_exp_t decode_div(input logic [DIVCFG_W-1:0] cfg);
        return div_exp_t'({cfg[3], cfg[1:0]}) + div_exp_t'(1);
    endfunction

    function automatic entry_t entry_unpack(input logic [ENTRY_W-1:0] w,
                                            input logic force_mask);
        entry_t e;
        e.periodic  = w[PER_BIT];
        e.masked    = w[MASK_BIT] | force_mask;
        e.send_pend = w[SENDP_BIT];
        e.vector    = w[VEC_W-1:0];
        return e;
    endfunction

    function automatic logic [ENTRY_W-1:0] entry_pack(input entry_t e);
        logic [ENTRY_W-1:0] w;
        w              = '0;
        w[PER_BIT]     = e.periodic;
        w[MASK_BIT]    = e.masked;
        w[SENDP_BIT]   = e.send_pend;
        w[VEC_W-1:0]   = e.vector;
        return w;
    endfunction

endpackage

// File: rtl/cdt_prescaler.sv
module cdt_prescaler
    import cdt_pkg::*;
#(
    parameter int PSC_W = MAX_EXP
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     restart,
    input  div_exp_t exp_sel,
    output logic     tick
);

    logic [PSC_W-1:0] phase_q;
    logic [PSC_W:0]   one_sh;
    logic [PSC_W-1:0] span;

    assign one_sh = (PSC_W+1)'(1) << exp_sel;
    assign span   = PSC_W'(one_sh - (PSC_W+1)'(1));
    assign tick   = ((phase_q & span) == span);

    always_ff @(posedge clk) begin
        if (rst || restart) phase_q <= '0;
        else                phase_q <= phase_q + PSC_W'(1);
    end

    // R1: after a restart the phase begins at zero
    assert_phase_restart_R1: assert property (@(posedge clk) disable iff (rst)
        restart |=> (phase_q == '0));

endmodule

// File: rtl/cdt_countdown.sv
module cdt_countdown #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             periodic,
    output logic [CNT_W-1:0] cur,
    output logic             expire
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cur_q;
    logic [CNT_W-1:0] start_q;
    logic             run_q;

    assign expire = tick && run_q && (cur_q == ONE);
    assign cur    = cur_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q   <= '0;
            start_q <= '0;
            run_q   <= 1'b0;
        end else if (load) begin
            cur_q   <= load_val;
            start_q <= load_val;
            run_q   <= (load_val != '0);
        end else if (tick && run_q) begin
            if (cur_q == ONE) begin
                if (periodic) begin
                    cur_q <= start_q;
                end else begin
                    cur_q <= '0;
                    run_q <= 1'b0;
                end
            end else begin
                cur_q <= cur_q - ONE;
            end
        end
    end

    // R2: a zero start value leaves the timer idle at zero
    assert_zero_halts_R2: assert property (@(posedge clk) disable iff (rst)
        (load && load_val == '0) |=> (cur_q == '0 && !run_q));

    // R4: a stopped timer keeps its count until reloaded
    assert_oneshot_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !load) |=> $stable(cur_q));

    // R5: periodic expiry reloads the start value
    assert_periodic_reload_R5: assert property (@(posedge clk) disable iff (rst)
        (expire && periodic && !load) |=> (cur_q == start_q && run_q));

endmodule

// File: rtl/cdt_pending.sv
module cdt_pending #(
    parameter int PEND_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              inc,
    input  logic              dec,
    output logic [PEND_W-1:0] count
);

    localparam logic [PEND_W-1:0] MAXV = {PEND_W{1'b1}};

    logic [PEND_W-1:0] cnt_q;

    assign count = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else begin
            case ({inc, dec})
                2'b10:   if (cnt_q != MAXV) cnt_q <= cnt_q + PEND_W'(1);
                2'b01:   if (cnt_q != '0)   cnt_q <= cnt_q - PEND_W'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R11: a full counter stays full on a further expiry
    assert_no_wrap_R11: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == MAXV && inc && !dec && !clr) |=> (cnt_q == MAXV));

    // R3: a clear request empties the counter
    assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0));

    // R6: an expiry with room adds exactly one
    assert_step_R6: assert property (@(posedge clk) disable iff (rst)
        (inc && !dec && !clr && cnt_q != MAXV) |=> (cnt_q == $past(cnt_q) + PEND_W'(1)));

endmodule

// File: rtl/divtimer.sv
module divtimer
    import cdt_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int PEND_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_enable,
    input  logic              init_wr,
    input  logic [CNT_W-1:0]  init_data,
    input  logic              div_wr,
    input  logic [3:0]        div_data,
    input  logic              entry_wr,
    input  logic [31:0]       entry_data,
    output logic [31:0]       entry_rd,
    output logic [CNT_W-1:0]  cur_count,
    output logic [PEND_W-1:0] pend_count,
    output logic              pend_valid,
    input  logic              deliver
);

    logic [DIVCFG_W-1:0] div_cfg_q;
    entry_t              entry_q;
    div_exp_t            exp_sel;
    logic                tick;
    logic                expire;
    logic                take;

    assign exp_sel = decode_div(div_cfg_q);

    always_ff @(posedge clk) begin
        if (rst)         div_cfg_q <= '0;
        else if (div_wr) div_cfg_q <= div_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            entry_q <= ENTRY_RESET;
        end else if (entry_wr) begin
            entry_q <= entry_unpack(entry_data, !sw_enable);
        end else if (!sw_enable) begin
            entry_q.masked <= 1'b1;
        end
    end

    cdt_prescaler #(.PSC_W(MAX_EXP)) u_psc (
        .clk     (clk),
        .rst     (rst),
        .restart (init_wr),
        .exp_sel (exp_sel),
        .tick    (tick)
    );

    cdt_countdown #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (init_wr),
        .load_val (init_data),
        .tick     (tick),
        .periodic (entry_q.periodic),
        .cur      (cur_count),
        .expire   (expire)
    );

    assign pend_valid = sw_enable && !entry_q.masked && (pend_count != '0);
    assign take       = deliver && pend_valid;

    cdt_pending #(.PEND_W(PEND_W)) u_pend (
        .clk   (clk),
        .rst   (rst),
        .clr   (init_wr || !sw_enable),
        .inc   (expire),
        .dec   (take),
        .count (pend_count)
    );

    assign entry_rd = entry_pack(entry_q);

    // R8: disabling forces the mask and empties the pending count
    assert_mask_forced_R8: assert property (@(posedge clk) disable iff (rst)
        !sw_enable |=> (entry_rd[MASK_BIT] && pend_count == '0));

    // R9: unkept entry bits never read back as one
    assert_entry_clean_R9: assert property (@(posedge clk) disable iff (rst)
        entry_wr |=> (entry_rd[31:18] == '0 && entry_rd[15:13] == '0 && entry_rd[11:8] == '0));

endmodule

// File: tb/divtimer_tb.sv
module divtimer_tb;

    localparam int CNT_W  = 32;
    localparam int PEND_W = 4;

    logic              clk = 1'b0;
    logic              rst;
    logic              sw_enable;
    logic              init_wr;
    logic [CNT_W-1:0]  init_data;
    logic              div_wr;
    logic [3:0]        div_data;
    logic              entry_wr;
    logic [31:0]       entry_data;
    logic [31:0]       entry_rd;
    logic [CNT_W-1:0]  cur_count;
    logic [PEND_W-1:0] pend_count;
    logic              pend_valid;
    logic              deliver;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    divtimer #(.CNT_W(CNT_W), .PEND_W(PEND_W)) u_dut (
        .clk(clk), .rst(rst), .sw_enable(sw_enable),
        .init_wr(init_wr), .init_data(init_data),
        .div_wr(div_wr), .div_data(div_data),
        .entry_wr(entry_wr), .entry_data(entry_data),
        .entry_rd(entry_rd), .cur_count(cur_count),
        .pend_count(pend_count), .pend_valid(pend_valid),
        .deliver(deliver)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_init(input logic [31:0] v);
        init_wr = 1'b1; init_data = v; step(1); init_wr = 1'b0;
    endtask

    task automatic wr_div(input logic [3:0] v);
        div_wr = 1'b1; div_data = v; step(1); div_wr = 1'b0;
    endtask

    task automatic wr_entry(input logic [31:0] v);
        entry_wr = 1'b1; entry_data = v; step(1); entry_wr = 1'b0;
    endtask

    task automatic test_reset;
        chk("R3 reset count", cur_count, 0);
        chk("R8 reset entry masked", entry_rd, 32'h0001_0000);
        chk("R6 reset pending", 32'(pend_count), 0);
        chk("R7 reset not offered", 32'(pend_valid), 0);
    endtask

    task automatic test_divider;
        wr_div(4'hB); wr_init(10); step(3);
        chk("R1 div1 count", cur_count, 7);
        wr_div(4'h0); wr_init(100); step(6);
        chk("R1 div2 count", cur_count, 97);
        wr_div(4'h4); wr_init(100); step(6);
        chk("R1 bit2 ignored", cur_count, 97);
        wr_div(4'h8); wr_init(100); step(63);
        chk("R1 div32 before step", cur_count, 99);
        step(1);
        chk("R1 div32 after step", cur_count, 98);
    endtask

    task automatic test_div_change;
        wr_div(4'hB); wr_init(100); step(10);
        chk("R10 before change", cur_count, 90);
        wr_div(4'h0);
        chk("R10 no restart", cur_count, 89);
        step(3);
        chk("R10 slower rate", cur_count, 87);
        step(1);
        chk("R10 held between steps", cur_count, 87);
        step(1);
        chk("R10 next step", cur_count, 86);
    endtask

    task automatic test_zero;
        wr_div(4'hB); wr_init(0); step(50);
        chk("R2 zero count", cur_count, 0);
        chk("R2 no expiry", 32'(pend_count), 0);
    endtask

    task automatic test_oneshot;
        wr_entry(32'h0000_0041); wr_div(4'hB); wr_init(5); step(4);
        chk("R4 one step before", cur_count, 1);
        chk("R4 no expiry yet", 32'(pend_count), 0);
        step(1);
        chk("R4 reached zero", cur_count, 0);
        chk("R4 one expiry", 32'(pend_count), 1);
        step(20);
        chk("R4 stays zero", cur_count, 0);
        chk("R4 no further expiry", 32'(pend_count), 1);
    endtask

    task automatic test_periodic;
        wr_entry(32'h0002_0042); wr_div(4'hB); wr_init(4); step(4);
        chk("R5 reload", cur_count, 4);
        chk("R5 first expiry", 32'(pend_count), 1);
        step(3);
        chk("R5 keeps running", cur_count, 1);
        step(1);
        chk("R5 second reload", cur_count, 4);
        chk("R5 second expiry", 32'(pend_count), 2);
    endtask

    task automatic test_delivery;
        wr_entry(32'h0002_0043); wr_div(4'hB); wr_init(3); step(9);
        chk("R6 three expiries", 32'(pend_count), 3);
        wr_entry(32'h0000_0043);
        step(5);
        chk("R6 four expiries", 32'(pend_count), 4);
        chk("R7 offered", 32'(pend_valid), 1);
        deliver = 1'b1; step(1); deliver = 1'b0;
        chk("R6 delivery removes one", 32'(pend_count), 3);
        wr_entry(32'h0001_0043);
        chk("R7 masked not offered", 32'(pend_valid), 0);
        deliver = 1'b1; step(1); deliver = 1'b0;
        chk("R7 masked delivery ignored", 32'(pend_count), 3);
        wr_entry(32'h0000_0043);
        chk("R7 offered again", 32'(pend_valid), 1);
    endtask

    task automatic test_saturate;
        wr_entry(32'h0002_0044); wr_div(4'hB); wr_init(1); step(20);
        chk("R11 saturated", 32'(pend_count), 15);
    endtask

    task automatic test_disable;
        sw_enable = 1'b0; step(1);
        chk("R8 mask forced", 32'(entry_rd[16]), 1);
        chk("R8 pending cleared", 32'(pend_count), 0);
        wr_entry(32'h0002_0033);
        chk("R8 write while disabled masked", entry_rd, 32'h0003_0033);
        step(3);
        chk("R8 pending held zero", 32'(pend_count), 0);
        sw_enable = 1'b1; step(2);
        chk("R7 masked after enable", 32'(pend_valid), 0);
    endtask

    task automatic test_restart;
        chk("R3 pending before restart", 32'(pend_count != 0), 1);
        wr_init(50);
        chk("R3 restart count", cur_count, 50);
        chk("R3 restart clears pending", 32'(pend_count), 0);
    endtask

    task automatic test_entry_bits;
        wr_entry(32'hFFFF_FFFF);
        chk("R9 kept bits only", entry_rd, 32'h0003_10FF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; sw_enable = 1'b1; init_wr = 1'b0; init_data = '0;
        div_wr = 1'b0; div_data = '0; entry_wr = 1'b0; entry_data = '0;
        deliver = 1'b0;
        step(3);
        rst = 1'b0;
        step(1);
        test_reset();
        test_divider();
        test_div_change();
        test_zero();
        test_oneshot();
        test_periodic();
        test_delivery();
        test_saturate();
        test_disable();
        test_restart();
        test_entry_bits();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule